// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block is a direct-mapped cache that sits between a word-addressed processor port and a slower main-memory port. Each word address is split into three fields. From most to least significant they are the tag, the slot index and the word offset. Every memory block can live in exactly one slot. That slot is shared by all blocks with the same index, and it holds the block's words together with a tag, a valid flag and a dirty flag.

A read hit answers one cycle after the request. On a miss the block raises `cpu_busy` and fetches the whole block from memory, one word per beat, starting at offset zero. If the slot being replaced holds modified data, that old block is first written back beat by beat. The requested word of a read miss is handed to the processor as soon as its beat arrives, before the rest of the block has landed. Writes are kept in the cache and marked dirty. A write miss first allocates the block, then merges the written word in. Memory only sees modified data when a block is evicted.

Top module: `dmc_cache`

## Requirements
- R1: The word address `cpu_addr` is decoded as offset = bits [WORD_LG-1:0], slot = the next SLOT_LG bits, tag = the remaining upper bits. Two addresses hit the same cached block exactly when their slot and tag fields both match.
- R2: After reset every slot is invalid, so the first access to any address is a miss. While reset is held, `cpu_busy`, `cpu_ack` and `mem_req` are low.
- R3: A read accepted while `cpu_busy` is low that hits returns the stored word on `cpu_rdata` with `cpu_ack` high in the next cycle. `cpu_busy` stays low.
- R4: A miss fetches all 2^WORD_LG words of the new block with read beats (`mem_we` low) at the block's consecutive addresses, offset zero first. A beat completes in a cycle with `mem_req` and `mem_ready` both high. While `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold.
- R5: On a read miss `cpu_busy` is high from the cycle after acceptance until the fill ends. `cpu_ack` with the requested word appears in the cycle after the beat that carries it, even if later beats are still pending.
- R6: A write hit updates only the cached word and marks the slot dirty. It starts no memory beat.
- R7: A write miss fills the block from memory, replaces the addressed word with the written data, marks the slot dirty and acknowledges when the fill ends. The other words of the block keep their memory values.
- R8: A miss to a slot that is valid and dirty first writes the old block back with 2^WORD_LG write beats to the old block's addresses, immediately followed by the fill. A miss to a clean slot writes nothing.
- R9: Requests presented while `cpu_busy` is high are ignored and change neither cached data nor memory.
- R10: With four slots of sixteen words, reading words 48 to 95 once and then words 15 to 31 ten times gives 5 misses and 213 hits.
- R11: Every accepted request produces exactly one `cpu_ack` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request strobe, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Miss handling in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the beat this cycle |

## Verification
The bench builds the cache with its defaults: a 16-bit word address, 32-bit words, four slots and sixteen-word blocks, giving a 10-bit tag. With only four slots, an address range of a thousand words maps many tags onto each slot. The random phase therefore produces frequent conflict evictions of both clean and dirty blocks, and the loop pattern of R10 fits the geometry exactly. A randomly stalling memory handshake places the load-through beat, the write-back-to-fill turnover and the last fill beat at varied distances from the request.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
    parameter int SLOT_LG = 2,
    parameter int TAG_W   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLOT_LG-1:0] rd_slot,
    output logic [TAG_W-1:0]   rd_tag,
    output logic               rd_valid,
    output logic               rd_dirty,
    input  logic               wr_en,
    input  logic [SLOT_LG-1:0] wr_slot,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_dirty
);
    localparam int SLOTS = 1 << SLOT_LG;

    logic [TAG_W-1:0] tag_q   [SLOTS];
    logic             valid_q [SLOTS];
    logic             dirty_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (wr_en && wr_slot == SLOT_LG'(g)) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= wr_dirty;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_LG'(g)) tag_q[g] <= wr_tag;
        end
    end

    assign rd_tag   = tag_q[rd_slot];
    assign rd_valid = valid_q[rd_slot];
    assign rd_dirty = dirty_q[rd_slot];

    // R2: a write from the controller always leaves the slot valid
    a_r2_written_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_slot == wr_slot) |=> rd_valid || (rd_slot != $past(wr_slot)));
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[wr_idx] <= wr_data;
    end

    assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int SLOT_LG = 2,
    parameter int WORD_LG = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    output logic [DATA_W-1:0]          cpu_rdata,
    output logic                       cpu_ack,
    output logic                       cpu_busy,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_ready,
    output logic [SLOT_LG-1:0]         ts_rd_slot,
    input  logic [ADDR_W-SLOT_LG-WORD_LG-1:0] ts_rd_tag,
    input  logic                       ts_rd_valid,
    input  logic                       ts_rd_dirty,
    output logic                       ts_wr_en,
    output logic [SLOT_LG-1:0]         ts_wr_slot,
    output logic [ADDR_W-SLOT_LG-WORD_LG-1:0] ts_wr_tag,
    output logic                       ts_wr_dirty,
    output logic [SLOT_LG+WORD_LG-1:0] ds_rd_idx,
    input  logic [DATA_W-1:0]          ds_rd_data,
    output logic                       ds_wr_en,
    output logic [SLOT_LG+WORD_LG-1:0] ds_wr_idx,
    output logic [DATA_W-1:0]          ds_wr_data
);
    localparam int TAG_W = ADDR_W - SLOT_LG - WORD_LG;

    typedef struct packed {
        dmc_state_e          st;
        logic [WORD_LG-1:0]  beat;
        logic [ADDR_W-1:0]   addr;
        logic                we;
        logic [DATA_W-1:0]   wdata;
        logic                ack;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    regs_t q, d;

    logic [SLOT_LG-1:0] cpu_slot, q_slot;
    logic [WORD_LG-1:0] cpu_off, q_off;
    logic [TAG_W-1:0]   cpu_tag, q_tag;
    logic               idle, hit, last_beat;

    assign cpu_slot  = cpu_addr[WORD_LG +: SLOT_LG];
    assign cpu_off   = cpu_addr[WORD_LG-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign q_slot    = q.addr[WORD_LG +: SLOT_LG];
    assign q_off     = q.addr[WORD_LG-1:0];
    assign q_tag     = q.addr[ADDR_W-1 -: TAG_W];
    assign idle      = (q.st == ST_IDLE);
    assign last_beat = (q.beat == {WORD_LG{1'b1}});
    assign hit       = ts_rd_valid && (ts_rd_tag == cpu_tag);

    always_comb begin
        d           = q;
        d.ack       = 1'b0;
        ts_rd_slot  = idle ? cpu_slot : q_slot;
        ds_rd_idx   = idle ? {cpu_slot, cpu_off} : {q_slot, q.beat};
        ts_wr_en    = 1'b0;
        ts_wr_slot  = q_slot;
        ts_wr_tag   = q_tag;
        ts_wr_dirty = 1'b0;
        ds_wr_en    = 1'b0;
        ds_wr_idx   = {q_slot, q.beat};
        ds_wr_data  = mem_rdata;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = {q_tag, q_slot, q.beat};
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    d.beat  = '0;
                    if (hit) begin
                        d.ack = 1'b1;
                        if (cpu_we) begin
                            ds_wr_en    = 1'b1;
                            ds_wr_idx   = {cpu_slot, cpu_off};
                            ds_wr_data  = cpu_wdata;
                            ts_wr_en    = 1'b1;
                            ts_wr_slot  = cpu_slot;
                            ts_wr_tag   = ts_rd_tag;
                            ts_wr_dirty = 1'b1;
                        end else begin
                            d.rdata = ds_rd_data;
                        end
                    end else if (ts_rd_valid && ts_rd_dirty) begin
                        d.st = ST_WBACK;
                    end else begin
                        d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {ts_rd_tag, q_slot, q.beat};
                if (mem_ready) begin
                    d.beat = q.beat + 1'b1;
                    if (last_beat) d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    ds_wr_en   = 1'b1;
                    ds_wr_data = (q.we && q.beat == q_off) ? q.wdata : mem_rdata;
                    if (!q.we && q.beat == q_off) begin
                        d.ack   = 1'b1;
                        d.rdata = mem_rdata;
                    end
                    d.beat = q.beat + 1'b1;
                    if (last_beat) begin
                        ts_wr_en    = 1'b1;
                        ts_wr_dirty = q.we;
                        d.st        = ST_IDLE;
                        if (q.we) d.ack = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.beat  <= '0;
            q.addr  <= '0;
            q.we    <= 1'b0;
            q.wdata <= '0;
            q.ack   <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_rdata = q.rdata;
    assign cpu_ack   = q.ack;
    assign cpu_busy  = !idle;

    a_r3_hit_answers: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_req && hit) |=> (cpu_ack && !cpu_busy));

    a_r5_miss_stalls: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_req && !hit) |=> (cpu_busy && !cpu_ack));

    a_r6_write_hit_quiet: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_req && cpu_we && hit) |=> !mem_req);

    a_r4_beat_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready && last_beat) |=> (mem_req && !mem_we));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int SLOT_LG = 2,
    parameter int WORD_LG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int TAG_W = ADDR_W - SLOT_LG - WORD_LG;
    localparam int IDX_W = SLOT_LG + WORD_LG;

    logic [SLOT_LG-1:0] ts_rd_slot, ts_wr_slot;
    logic [TAG_W-1:0]   ts_rd_tag, ts_wr_tag;
    logic               ts_rd_valid, ts_rd_dirty, ts_wr_en, ts_wr_dirty;
    logic [IDX_W-1:0]   ds_rd_idx, ds_wr_idx;
    logic [DATA_W-1:0]  ds_rd_data, ds_wr_data;
    logic               ds_wr_en;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LG(SLOT_LG), .WORD_LG(WORD_LG)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ts_rd_slot(ts_rd_slot), .ts_rd_tag(ts_rd_tag), .ts_rd_valid(ts_rd_valid),
        .ts_rd_dirty(ts_rd_dirty), .ts_wr_en(ts_wr_en), .ts_wr_slot(ts_wr_slot),
        .ts_wr_tag(ts_wr_tag), .ts_wr_dirty(ts_wr_dirty),
        .ds_rd_idx(ds_rd_idx), .ds_rd_data(ds_rd_data), .ds_wr_en(ds_wr_en),
        .ds_wr_idx(ds_wr_idx), .ds_wr_data(ds_wr_data)
    );

    dmc_tag_array #(.SLOT_LG(SLOT_LG), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst(rst),
        .rd_slot(ts_rd_slot), .rd_tag(ts_rd_tag), .rd_valid(ts_rd_valid), .rd_dirty(ts_rd_dirty),
        .wr_en(ts_wr_en), .wr_slot(ts_wr_slot), .wr_tag(ts_wr_tag), .wr_dirty(ts_wr_dirty)
    );

    dmc_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) data_i (
        .clk(clk),
        .rd_idx(ds_rd_idx), .rd_data(ds_rd_data),
        .wr_en(ds_wr_en), .wr_idx(ds_wr_idx), .wr_data(ds_wr_data)
    );

    assign mem_wdata = ds_rd_data;
endmodule

// File: tb/dmc_cache_tb_top.sv
`timescale 1ns/1ps
module dmc_cache_tb_top;
    localparam int AW = 16, DW = 32, SL = 2, WL = 4;
    localparam int NS = 1 << SL, NW = 1 << WL, BM = 4096;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic          cpu_ack, cpu_busy;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    dmc_cache #(.ADDR_W(AW), .DATA_W(DW), .SLOT_LG(SL), .WORD_LG(WL)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    logic [DW-1:0] bmem [BM];
    logic [DW-1:0] gold [BM];
    int  wcount = 0, rcount = 0, cyc = 0;
    int  checks = 0, errors = 0;
    int  hits = 0, misses = 0;
    int  mtag [NS];
    bit  mval [NS];
    bit  mdty [NS];
    bit  last_hit, last_busy_at_ack;
    logic [DW-1:0] last_rdata;

    function automatic logic [DW-1:0] pat(int i);
        return 32'h5A000000 + i * 32'h00010003;
    endfunction

    assign mem_rdata = bmem[mem_addr[11:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                bmem[mem_addr[11:0]] <= mem_wdata;
                wcount <= wcount + 1;
            end else begin
                rcount <= rcount + 1;
            end
        end
    end

    initial begin
        mem_ready = 1'b0;
        forever begin
            @(negedge clk);
            mem_ready = ($urandom % 4) != 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic access(input int a, input bit we, input logic [DW-1:0] wd,
                          input bit intrude, input int ib);
        int s, t, w0, r0, expw, nack;
        bit eh;
        s = (a >> WL) % NS;
        t = a >> (WL + SL);
        eh = mval[s] && mtag[s] == t;
        expw = (!eh && mval[s] && mdty[s]) ? NW : 0;
        w0 = wcount;
        r0 = rcount;
        nack = 0;
        last_busy_at_ack = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a[AW-1:0]; cpu_wdata = wd;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (cpu_ack && !cpu_busy) begin
            last_hit = 1'b1;
            nack++;
            last_rdata = cpu_rdata;
        end else begin
            last_hit = 1'b0;
            if (cpu_ack) nack++;
            while (cpu_busy) begin
                if (intrude) begin
                    @(negedge clk);
                    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ib[AW-1:0]; cpu_wdata = 32'hDEADBEEF;
                end
                @(posedge clk); #1;
                cpu_req = 1'b0; cpu_we = 1'b0;
                if (cpu_ack) begin
                    nack++;
                    last_rdata = cpu_rdata;
                    last_busy_at_ack = cpu_busy;
                end
            end
        end
        // R1 and R2: hit or miss follows the slot/tag decode of an initially empty cache
        chk(last_hit == eh, "R1 hit-or-miss decision", 32'(last_hit), 32'(eh));
        chk(nack == 1, "R11 one ack per request", nack, 1);
        if (!we) chk(last_rdata == gold[a], "R3 read data", last_rdata, gold[a]);
        else gold[a] = wd;
        chk(wcount - w0 == expw, "R8 write-back beat count", wcount - w0, expw);
        chk(rcount - r0 == (eh ? 0 : NW), "R4 fill beat count", rcount - r0, eh ? 0 : NW);
        if (eh) begin
            hits++;
            mdty[s] = mdty[s] | we;
        end else begin
            misses++;
            mval[s] = 1'b1; mtag[s] = t; mdty[s] = we;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired actual %0d expected %0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < BM; i++) begin
            bmem[i] = pat(i);
            gold[i] = pat(i);
        end
        for (int i = 0; i < NS; i++) begin
            mval[i] = 1'b0; mdty[i] = 1'b0; mtag[i] = 0;
        end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (4) @(posedge clk);
        #1;
        chk(!cpu_busy && !cpu_ack && !mem_req, "R2 outputs idle in reset",
            {29'd0, cpu_busy, cpu_ack, mem_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R10: sequential run then a short loop
        hits = 0; misses = 0;
        for (int a = 48; a <= 95; a++) access(a, 1'b0, '0, 1'b0, 0);
        for (int k = 0; k < 10; k++)
            for (int a = 15; a <= 31; a++) access(a, 1'b0, '0, 1'b0, 0);
        chk(misses == 5, "R10 miss count", misses, 5);
        chk(hits == 213, "R10 hit count", hits, 213);

        // R5: load-through answers before the fill ends
        access(32'h203, 1'b0, '0, 1'b0, 0);
        chk(!last_hit && last_busy_at_ack, "R5 word forwarded during fill",
            32'(last_busy_at_ack), 32'd1);

        // R6: write hit stays in the cache
        access(32'h204, 1'b1, 32'h12345678, 1'b0, 0);
        chk(last_hit, "R6 write hit", 32'(last_hit), 32'd1);
        chk(bmem[12'h204] == pat(32'h204), "R6 memory untouched", bmem[12'h204], pat(32'h204));

        // R8: dirty eviction writes the old block back; clean eviction writes nothing
        access(32'h304, 1'b0, '0, 1'b0, 0);
        chk(bmem[12'h204] == 32'h12345678, "R8 written back", bmem[12'h204], 32'h12345678);
        access(32'h404, 1'b0, '0, 1'b0, 0);

        // R7: write miss allocates, merges and leaves neighbours from memory
        access(32'h505, 1'b1, 32'hCAFEF00D, 1'b0, 0);
        chk(!last_hit, "R7 write miss", 32'(last_hit), 32'd0);
        access(32'h505, 1'b0, '0, 1'b0, 0);
        chk(last_hit && last_rdata == 32'hCAFEF00D, "R7 merged word", last_rdata, 32'hCAFEF00D);
        access(32'h50A, 1'b0, '0, 1'b0, 0);
        chk(last_hit, "R7 neighbour filled", 32'(last_hit), 32'd1);
        access(32'h605, 1'b0, '0, 1'b0, 0);
        chk(bmem[12'h505] == 32'hCAFEF00D, "R7 dirty after allocate", bmem[12'h505], 32'hCAFEF00D);

        // R9: writes offered while busy are dropped
        access(32'h703, 1'b0, '0, 1'b1, 32'h010);
        access(32'h010, 1'b0, '0, 1'b0, 0);
        chk(last_rdata == gold[32'h010], "R9 intruding write ignored", last_rdata, gold[32'h010]);
        access(32'h810, 1'b0, '0, 1'b0, 0);

        // Random mix over a range that aliases heavily onto four slots
        for (int n = 0; n < 400; n++) begin
            int a;
            bit w;
            a = int'($urandom % 1024);
            w = ($urandom % 10) < 3;
            access(a, w, $urandom, 1'b0, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule